// File: doc/BRIEF.md
# Eight-Channel Output Protection and Fault Latch

This block sits between the output-request logic and the gate drivers of an eight-channel low-side switch. Each channel has its own state machine. It takes the requested on/off level and the four fault-detector flags of that channel: current limiting active, over-temperature, open load and short to ground. From these it decides whether the gate may be driven. It also filters and latches a two-bit diagnosis code, and it gathers the eight codes into a 16-bit diagnosis word. An active-low general fault output goes low while any latched code is not "normal".

Each channel has two mode bits. The overload mode bit picks between current limiting that keeps running and a shutdown that latches. The over-temperature mode bit picks between restarting by itself after cooling and a shutdown that latches. A latched shutdown is released only when the request goes low and then high again. A one-cycle valid-frame strobe from the serial front end clears every latched code and restarts the filter timers. It does not release latched shutdowns. The filter time and the overload switch-off delay are parameters counted in clock cycles.

Each channel has four states. `ST_OFF` is idle with the gate off. `ST_ON` drives the gate. `ST_COOL` holds the gate off after an over-temperature trip while auto-restart is selected. `ST_LOCK` holds the gate off after a latched trip. The transitions are:
- OFF→ON when the request is high.
- ON→OFF, COOL→OFF and LOCK→OFF when the request is low.
- ON→COOL on over-temperature with the over-temperature mode bit 0.
- ON→LOCK on over-temperature with that bit 1, or when the overload switch-off timer expires with the overload mode bit 1.
- COOL→ON when the over-temperature flag has cleared and the request is still high.

Top module: `chg_top`

## Requirements
- R1: Each channel's diagnosis code sits at diag_word[2i+1:2i] for channel index i (0..7). The codes are 2'b11 normal, 2'b10 overload or over-temperature, 2'b01 open load and 2'b00 short to ground. Every code is 2'b11 after reset.
- R2: fault_n is 0 whenever any channel code differs from 2'b11, and 1 otherwise.
- R3: With the overload mode bit 0, a channel that is on and limiting current stays on. Its code becomes 2'b10 once limiting has been present for FILT_CYC+1 consecutive cycles, and not before.
- R4: With the overload mode bit 1, a channel that has limited current for OFF_CYC+1 consecutive cycles while on turns off in that cycle and reports 2'b10. It stays off after limiting stops, until its request goes low and then high again.
- R5: Over-temperature while on turns the gate off on the next clock edge and reports 2'b10. With the over-temperature mode bit 0, the channel stays off while the flag is high and turns on again one cycle after the flag clears, if the request is still high.
- R6: With the over-temperature mode bit 1, a channel tripped by over-temperature stays off after the flag clears, until its request goes low and then high again.
- R7: Over-temperature has no effect on a channel that is off. Open-load and short-to-ground flags have no effect on a channel that is on.
- R8: A channel that is off and has the open-load or short-to-ground flag present for FILT_CYC+1 consecutive cycles reports 2'b01 for open load or 2'b00 for short to ground. Short to ground wins when both flags are present.
- R9: A valid-frame strobe sets every code to 2'b11 and restarts all filter timers. A fault event that latches in the same cycle as the strobe is kept.
- R10: Reset forces all gates off. With no fault, gate_en[i] follows req[i] one clock later.
- R11: A new fault on a channel overwrites the code that channel latched earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCH | Requested on/off level per channel |
| cl_flag | input | NCH | Current-limit active per channel |
| ot_flag | input | NCH | Over-temperature detected per channel |
| ol_flag | input | NCH | Open load detected per channel |
| sg_flag | input | NCH | Short to ground detected per channel |
| ovl_latch | input | NCH | Overload mode: 1 = latching shutdown |
| ovt_latch | input | NCH | Over-temperature mode: 1 = latching shutdown |
| frame_ok | input | 1 | Valid-frame strobe, clears codes |
| gate_en | output | NCH | Final gate enable per channel |
| diag_word | output | 2*NCH | Packed two-bit codes, channel 0 in the low bits |
| fault_n | output | 1 | General fault, active low |

## Verification
The bench targets the filter boundary: it checks the cycle just before a report and the cycle in which the report lands. A design that is off by one would flag or shut down a cycle early or a cycle late. It checks that a latched channel ignores a flag that clears and needs a fresh request edge. A design that used the flag alone would re-enable the gate too soon. It also covers a clear strobe arriving mid-filter, which must push a report a full window later, and a strobe that coincides with a fault event, which must not lose that event. Flags are applied in the wrong channel state (over-temperature while off, open load while on) to catch a design that latches codes it should ignore.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_COOL = 2'd2,
        ST_LOCK = 2'd3
    } chan_st_e;

    localparam logic [1:0] DG_OK    = 2'b11;
    localparam logic [1:0] DG_OVER  = 2'b10;
    localparam logic [1:0] DG_OPEN  = 2'b01;
    localparam logic [1:0] DG_SHORT = 2'b00;

endpackage

// File: rtl/chg_run_ctr.sv
// Counts consecutive cycles of a condition and saturates at all ones.
module chg_run_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         active,
    output logic [W-1:0] run
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (restart || !active) begin
            run <= '0;
        end else if (run != {W{1'b1}}) begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/chg_chan.sv
module chg_chan
    import chg_pkg::*;
#(
    parameter int FILT_CYC = 20000,
    parameter int OFF_CYC  = 6000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       cl,
    input  logic       ot,
    input  logic       ol,
    input  logic       sg,
    input  logic       ovl_hold,
    input  logic       ovt_hold,
    input  logic       clr,
    output logic       gate,
    output logic [1:0] code
);

    localparam int TOP_CYC = (FILT_CYC > OFF_CYC) ? FILT_CYC : OFF_CYC;
    localparam int CW      = $clog2(TOP_CYC + 2);
    localparam logic [CW-1:0] FILT_V = CW'(FILT_CYC);
    localparam logic [CW-1:0] OFF_V  = CW'(OFF_CYC);

    chan_st_e    st, st_nx;
    logic [1:0]  code_nx;
    logic [CW-1:0] cl_run, off_run;
    logic        on_now;
    logic        cl_cond, off_cond;
    logic        ot_trip, ovl_trip, cl_report, off_report;

    assign on_now   = (st == ST_ON);
    assign cl_cond  = on_now && cl;
    assign off_cond = !on_now && (ol || sg);

    chg_run_ctr #(.W(CW)) u_cl_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (clr),
        .active  (cl_cond),
        .run     (cl_run)
    );

    chg_run_ctr #(.W(CW)) u_off_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (clr),
        .active  (off_cond),
        .run     (off_run)
    );

    assign ot_trip    = on_now && req && ot;
    assign ovl_trip   = on_now && req && !ot && ovl_hold && cl && (cl_run == OFF_V);
    assign cl_report  = cl_cond && (cl_run == FILT_V);
    assign off_report = off_cond && (off_run == FILT_V);

    // state register (the latched code is held alongside it)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_OFF;
            code <= DG_OK;
        end else begin
            st   <= st_nx;
            code <= code_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF:  if (req) st_nx = ST_ON;
            ST_ON: begin
                if (!req)          st_nx = ST_OFF;
                else if (ot)       st_nx = ovt_hold ? ST_LOCK : ST_COOL;
                else if (ovl_trip) st_nx = ST_LOCK;
            end
            ST_COOL: begin
                if (!req)     st_nx = ST_OFF;
                else if (!ot) st_nx = ST_ON;
            end
            ST_LOCK: if (!req) st_nx = ST_OFF;
            default: st_nx = ST_OFF;
        endcase
    end

    // outputs and diagnosis update; events win over the clear strobe
    always_comb begin
        gate    = on_now;
        code_nx = code;
        if (clr)                          code_nx = DG_OK;
        if (ot_trip || ovl_trip || cl_report) code_nx = DG_OVER;
        else if (off_report)              code_nx = sg ? DG_SHORT : DG_OPEN;
    end

endmodule

// File: rtl/chg_top.sv
module chg_top
    import chg_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int FILT_CYC = 20000,
    parameter int OFF_CYC  = 6000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   cl_flag,
    input  logic [NCH-1:0]   ot_flag,
    input  logic [NCH-1:0]   ol_flag,
    input  logic [NCH-1:0]   sg_flag,
    input  logic [NCH-1:0]   ovl_latch,
    input  logic [NCH-1:0]   ovt_latch,
    input  logic             frame_ok,
    output logic [NCH-1:0]   gate_en,
    output logic [2*NCH-1:0] diag_word,
    output logic             fault_n
);

    localparam int DW = 2 * NCH;

    logic [NCH-1:0] ch_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [1:0] c;
        chg_chan #(
            .FILT_CYC (FILT_CYC),
            .OFF_CYC  (OFF_CYC)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req[i]),
            .cl       (cl_flag[i]),
            .ot       (ot_flag[i]),
            .ol       (ol_flag[i]),
            .sg       (sg_flag[i]),
            .ovl_hold (ovl_latch[i]),
            .ovt_hold (ovt_latch[i]),
            .clr      (frame_ok),
            .gate     (gate_en[i]),
            .code     (c)
        );
        assign diag_word[2*i +: 2] = c;
        assign ch_ok[i]            = (c == DG_OK);
    end

    assign fault_n = &ch_ok;

    logic [DW-1:0] unused_w;
    assign unused_w = diag_word;

endmodule

// File: rtl/chg_chk.sv
module chg_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   req,
    input logic [NCH-1:0]   cl_flag,
    input logic [NCH-1:0]   ot_flag,
    input logic [NCH-1:0]   ol_flag,
    input logic [NCH-1:0]   sg_flag,
    input logic             frame_ok,
    input logic [NCH-1:0]   gate_en,
    input logic [2*NCH-1:0] diag_word,
    input logic             fault_n
);

    // R2: any non-normal code pulls the general fault low
    p_fault_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_word != {2*NCH{1'b1}}) |-> !fault_n);

    // R9: a strobe with no fault flags present leaves every code normal
    p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && cl_flag == '0 && ot_flag == '0 && ol_flag == '0 && sg_flag == '0)
        |=> (diag_word == {2*NCH{1'b1}}));

    for (genvar i = 0; i < NCH; i++) begin : g_ck
        // R5: over-temperature while on drops the gate on the next edge
        p_ot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_en[i] && ot_flag[i]) |=> !gate_en[i]);

        // R10: a low request turns the gate off on the next edge
        p_req_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !req[i] |=> !gate_en[i]);

        // R10: the gate can only rise when the request was high
        p_rise_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_en[i]) |-> $past(req[i]));

        // R7: over-temperature on an off channel leaves a normal code alone
        p_ot_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!gate_en[i] && ot_flag[i] && !ol_flag[i] && !sg_flag[i]
             && diag_word[2*i +: 2] == 2'b11) |=> (diag_word[2*i +: 2] == 2'b11));
    end

endmodule

bind chg_top chg_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cl_flag   (cl_flag),
    .ot_flag   (ot_flag),
    .ol_flag   (ol_flag),
    .sg_flag   (sg_flag),
    .frame_ok  (frame_ok),
    .gate_en   (gate_en),
    .diag_word (diag_word),
    .fault_n   (fault_n)
);

// File: tb/tb_chg_top.sv
`timescale 1ns/1ps
module tb_chg_top;

    localparam int NCH  = 8;
    localparam int FILT = 8;
    localparam int OFFD = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  req = '0, cl_flag = '0, ot_flag = '0, ol_flag = '0, sg_flag = '0;
    logic [NCH-1:0]  ovl_latch = '0, ovt_latch = '0;
    logic            frame_ok = 1'b0;
    logic [NCH-1:0]  gate_en;
    logic [15:0]     diag_word;
    logic            fault_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    chg_top #(.NCH(NCH), .FILT_CYC(FILT), .OFF_CYC(OFFD)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .cl_flag(cl_flag), .ot_flag(ot_flag),
        .ol_flag(ol_flag), .sg_flag(sg_flag), .ovl_latch(ovl_latch),
        .ovt_latch(ovt_latch), .frame_ok(frame_ok), .gate_en(gate_en),
        .diag_word(diag_word), .fault_n(fault_n)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [7:0]  cl;
        logic [7:0]  ot;
        logic [7:0]  ol;
        logic [7:0]  sg;
        logic        clr;
        logic [7:0]  cyc;
        logic [7:0]  eg;
        logic [15:0] ed;
        logic        ef;
        logic [3:0]  tag;
    } row_t;

    localparam int NR = 27;
    // overload mode bit set on index 1, over-temperature mode bit set on index 3
    localparam row_t TBL [NR] = '{
        '{8'h00,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'h00,16'hFFFF,1'b1,4'd10}, // R10 idle
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFF,16'hFFFF,1'b1,4'd10}, // R10 follow
        '{8'hFF,8'h01,8'h00,8'h00,8'h00,1'b0,8'd8, 8'hFF,16'hFFFF,1'b1,4'd3},  // R3 not yet
        '{8'hFF,8'h01,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFF,16'hFFFE,1'b0,4'd3},  // R3 reported, still on
        '{8'hFF,8'h03,8'h00,8'h00,8'h00,1'b0,8'd3, 8'hFF,16'hFFFE,1'b0,4'd4},  // R4 before delay
        '{8'hFF,8'h03,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFD,16'hFFFA,1'b0,4'd4},  // R4 shutdown
        '{8'hFF,8'h01,8'h00,8'h00,8'h00,1'b0,8'd2, 8'hFD,16'hFFFA,1'b0,4'd4},  // R4 stays off
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b1,8'd1, 8'hFD,16'hFFFF,1'b1,4'd9},  // R9 clear
        '{8'hFD,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFD,16'hFFFF,1'b1,4'd4},  // R4 request low
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFF,16'hFFFF,1'b1,4'd4},  // R4 new rise
        '{8'hFF,8'h00,8'h04,8'h00,8'h00,1'b0,8'd1, 8'hFB,16'hFFEF,1'b0,4'd5},  // R5 trip
        '{8'hFF,8'h00,8'h04,8'h00,8'h00,1'b0,8'd3, 8'hFB,16'hFFEF,1'b0,4'd5},  // R5 hot, off
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFF,16'hFFEF,1'b0,4'd5},  // R5 restart
        '{8'hFF,8'h00,8'h08,8'h00,8'h00,1'b0,8'd1, 8'hF7,16'hFFAF,1'b0,4'd6},  // R6 trip
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b0,8'd2, 8'hF7,16'hFFAF,1'b0,4'd6},  // R6 cooled, off
        '{8'hF7,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hF7,16'hFFAF,1'b0,4'd6},  // R6 request low
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b0,8'd1, 8'hFF,16'hFFAF,1'b0,4'd6},  // R6 new rise
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,1'b1,8'd1, 8'hFF,16'hFFFF,1'b1,4'd9},  // R9 clear
        '{8'h0F,8'h00,8'h00,8'h51,8'h60,1'b0,8'd9, 8'h0F,16'hFFFF,1'b1,4'd8},  // R8 not yet
        '{8'h0F,8'h00,8'h80,8'h51,8'h60,1'b0,8'd1, 8'h0F,16'hC1FF,1'b0,4'd1},  // R1 R8 codes
        '{8'h0F,8'h00,8'h80,8'h51,8'h60,1'b0,8'd20,8'h0F,16'hC1FF,1'b0,4'd7},  // R7 ignored
        '{8'h0F,8'h00,8'h80,8'h51,8'h60,1'b1,8'd1, 8'h0F,16'hFFFF,1'b1,4'd9},  // R9 clear
        '{8'h0F,8'h00,8'h80,8'h51,8'h60,1'b0,8'd8, 8'h0F,16'hFFFF,1'b1,4'd9},  // R9 restarted
        '{8'h0F,8'h00,8'h80,8'h51,8'h60,1'b0,8'd1, 8'h0F,16'hC1FF,1'b0,4'd9},  // R9 re-report
        '{8'h1F,8'h10,8'h00,8'h51,8'h60,1'b0,8'd1, 8'h1F,16'hC1FF,1'b0,4'd11}, // R11 on again
        '{8'h1F,8'h10,8'h00,8'h51,8'h60,1'b0,8'd8, 8'h1F,16'hC1FF,1'b0,4'd11}, // R11 filtering
        '{8'h1F,8'h10,8'h00,8'h51,8'h60,1'b0,8'd1, 8'h1F,16'hC2FF,1'b0,4'd11}  // R11 overwrite
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input int tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input int tag, input logic [7:0] eg, input logic [15:0] ed, input logic ef);
        chk("gate_en", tag, {8'h00, gate_en}, {8'h00, eg});
        chk("diag_word", tag, diag_word, ed);
        chk("fault_n", tag, {15'd0, fault_n}, {15'd0, ef});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        ovl_latch = 8'h02;
        ovt_latch = 8'h08;
        #12;
        // R10 R1 reset state
        check_all(10, 8'h00, 16'hFFFF, 1'b1);
        rst_n = 1'b1;
        step(1);

        for (int r = 0; r < NR; r++) begin
            req      = TBL[r].rq;
            cl_flag  = TBL[r].cl;
            ot_flag  = TBL[r].ot;
            ol_flag  = TBL[r].ol;
            sg_flag  = TBL[r].sg;
            frame_ok = TBL[r].clr;
            step(1);
            frame_ok = 1'b0;
            if (TBL[r].cyc > 1) step(int'(TBL[r].cyc) - 1);
            check_all(int'(TBL[r].tag), TBL[r].eg, TBL[r].ed, TBL[r].ef);
        end

        // R10: reset with requests high keeps gates off and codes normal
        req = 8'hFF; cl_flag = '0; ot_flag = '0; ol_flag = '0; sg_flag = '0;
        rst_n = 1'b0;
        step(2);
        check_all(10, 8'h00, 16'hFFFF, 1'b1);
        rst_n = 1'b1;
        step(1);
        check_all(10, 8'hFF, 16'hFFFF, 1'b1);

        // R9: a clear strobe that lands on a report edge does not lose the event
        cl_flag = 8'h01;
        step(FILT);
        check_all(9, 8'hFF, 16'hFFFF, 1'b1);
        frame_ok = 1'b1;
        step(1);
        frame_ok = 1'b0;
        check_all(9, 8'hFF, 16'hFFFE, 1'b0);

        // R9: plain clear afterwards returns to normal
        cl_flag = '0;
        frame_ok = 1'b1;
        step(1);
        frame_ok = 1'b0;
        check_all(9, 8'hFF, 16'hFFFF, 1'b1);

        finish_run();
    end

endmodule